// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave port that gives a host controller read and write access to a bank of thirty-two 8-bit configuration registers. The host drives a serial clock, a data line into the block and an active-low configuration select. The block answers on its own data line and also presents every register to the rest of the chip as a flat parallel bus. A second active-low select belongs to a separate data-path serial channel that shares the pins. The configuration port always takes precedence over that channel, and the block signals when the data path may own the bus.

Each access takes two bytes. The first is a header byte that holds framing bits, a direction bit and a register index. The second is the payload. While the payload shifts in, the block shifts the addressed register's current contents out, so a write also returns the value it replaces. If select stays low, further bytes continue to alternate between header and payload, so several registers can be accessed in one select window. Releasing select between the two bytes abandons the access.

All pin inputs are brought into the system clock domain through synchronizers, and the block acts on the detected serial clock edges. The registers reset synchronously to zero.

Top module: `spi_cfg_slave`

## Requirements
- R1: While `cfg_sel_n` is low, transfers proceed whatever the level of `dat_sel_n`. `dat_grant` is high only while the configuration select is high and `dat_sel_n` is low.
- R2: The header byte is sent MSB first. Bit 7 is a start bit that must be 0, bit 6 is the direction (1 = read, 0 = write), bits 5..1 are the register index, and bit 0 is a stop bit that must be 1. `mosi` is sampled on rising `sck` edges.
- R3: In a write, the payload byte, taken MSB first, replaces the indexed register after the 16th rising `sck` edge. It then appears on `cfg_regs[8*i+7:8*i]`.
- R4: During the payload byte, `miso` changes on falling `sck` edges and presents the register's contents MSB first, starting after the 8th falling edge. In a write, this is the value held before the update.
- R5: A read access (direction bit 1, payload all zeros) leaves the register unchanged.
- R6: `miso_oe` is low while the configuration select is high, and high while it is low.
- R7: If select rises after only the header byte, no register changes, and the next byte after select falls again is taken as a header.
- R8: While select stays low, bytes alternate between header and payload roles, so back-to-back accesses need no select toggle.
- R9: If a header has start bit 1 or stop bit 0, the payload that follows changes no register.
- R10: After reset, all registers read zero and `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| cfg_sel_n | input | 1 | Active-low configuration select |
| dat_sel_n | input | 1 | Active-low data-path channel select |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| dat_grant | output | 1 | Data-path channel may use the shared pins |
| cfg_regs | output | 256 | All registers, register i at bits 8*i+7..8*i |

## Verification
A bit counter that is off by one shows up within one access. Either the payload lands in the wrong register or shifted by a bit on `cfg_regs`, or the bits returned on `miso` come out shifted a position. A header latch that is not cleared when select rises lets an aborted or badly framed access corrupt a register on the next payload. That is visible on the parallel bus a few system cycles after the 16th serial edge. A stale output shift register returns the wrong old value in the first payload bit of the next access.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int REG_COUNT = 32;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = $clog2(REG_COUNT);
  localparam int FRAME_W   = 2 * DATA_W;
  localparam int CNT_W     = $clog2(FRAME_W);

  typedef struct packed {
    logic              ok;
    logic              rd;
    logic [ADDR_W-1:0] idx;
  } hdr_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  input  logic sel_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic sel_act
);
  logic [STAGES:0] sck_q;
  logic [STAGES-1:0] mosi_q;
  logic [STAGES-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      mosi_q <= '0;
      sel_q  <= '1;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
      sel_q  <= {sel_q[STAGES-2:0], sel_n};
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign mosi_s   = mosi_q[STAGES-1];
  assign sel_act  = ~sel_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output hdr_t              hdr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_load,
  output logic              out_shift
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] PAY_FIRST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] in_sh;
  logic [DATA_W-1:0] byte_now;

  assign byte_now = {in_sh[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      in_sh   <= '0;
      hdr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!sel_act) begin
        bit_cnt <= '0;
        hdr.ok  <= 1'b0;
      end else if (sck_rise) begin
        in_sh   <= byte_now;
        bit_cnt <= (bit_cnt == PAY_LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == HDR_LAST) begin
          hdr.ok  <= ~byte_now[DATA_W-1] & byte_now[0];
          hdr.rd  <= byte_now[DATA_W-2];
          hdr.idx <= byte_now[ADDR_W:1];
        end
        if (bit_cnt == PAY_LAST) begin
          wr_en   <= hdr.ok & ~hdr.rd;
          wr_addr <= hdr.idx;
          wr_data <= byte_now;
          hdr.ok  <= 1'b0;
        end
      end
    end
  end

  assign out_load  = sel_act & sck_fall & (bit_cnt == PAY_FIRST);
  assign out_shift = sel_act & sck_fall & (bit_cnt > PAY_FIRST);
endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
  import spi_cfg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [REG_COUNT*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] mem [REG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
    assign flat[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sck,
  input  logic                        mosi,
  input  logic                        cfg_sel_n,
  input  logic                        dat_sel_n,
  output logic                        miso,
  output logic                        miso_oe,
  output logic                        dat_grant,
  output logic [REG_COUNT*DATA_W-1:0] cfg_regs
);
  logic              sck_rise, sck_fall, mosi_s, sel_act;
  logic [CNT_W-1:0]  bit_cnt;
  hdr_t              hdr;
  logic              wr_en, out_load, out_shift;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data, out_sh;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .sel_n(cfg_sel_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .sel_act(sel_act)
  );

  spi_cfg_frame u_frame (
    .clk(clk), .rst(rst), .sel_act(sel_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .bit_cnt(bit_cnt), .hdr(hdr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_load(out_load), .out_shift(out_shift)
  );

  spi_cfg_regbank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(hdr.idx), .rd_data(rd_data), .flat(cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sh    <= '0;
      miso_oe   <= 1'b0;
      dat_grant <= 1'b0;
    end else begin
      miso_oe   <= sel_act;
      dat_grant <= ~sel_act & ~dat_sel_n;
      if (out_load)       out_sh <= rd_data;
      else if (out_shift) out_sh <= {out_sh[DATA_W-2:0], 1'b0};
    end
  end

  assign miso = out_sh[DATA_W-1];
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
  import spi_cfg_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        sel_act,
  input logic                        sck_fall,
  input logic [CNT_W-1:0]            bit_cnt,
  input logic                        wr_en,
  input hdr_t                        hdr,
  input logic                        miso,
  input logic                        miso_oe,
  input logic                        dat_grant,
  input logic [REG_COUNT*DATA_W-1:0] cfg_regs
);
  a_r1_grant_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dat_grant && miso_oe));

  a_r6_hiz_when_idle: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> !miso_oe);

  a_r8_count_cleared: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> bit_cnt == '0);

  a_r3_regs_change_on_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_regs) |-> $past(wr_en));

  a_r9_write_needs_framing: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(hdr.ok) && !$past(hdr.rd));

  a_r4_miso_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$past(sck_fall) |-> $stable(miso));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (
  .clk(clk), .rst(rst), .sel_act(sel_act), .sck_fall(sck_fall),
  .bit_cnt(bit_cnt), .wr_en(wr_en), .hdr(hdr), .miso(miso),
  .miso_oe(miso_oe), .dat_grant(dat_grant), .cfg_regs(cfg_regs)
);

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
  localparam int HALF = 8;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, cfg_sel_n = 1'b1, dat_sel_n = 1'b1;
  logic miso, miso_oe, dat_grant;
  logic [NREG*8-1:0] cfg_regs;
  int vectors = 0, errors = 0;
  logic [7:0] shadow [NREG];

  always #10 clk = ~clk;

  spi_cfg_slave uut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cfg_sel_n(cfg_sel_n),
    .dat_sel_n(dat_sel_n), .miso(miso), .miso_oe(miso_oe),
    .dat_grant(dat_grant), .cfg_regs(cfg_regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] hdr_byte(input logic rd, input logic [4:0] idx);
    return {1'b0, rd, idx, 1'b1};
  endfunction

  task automatic shift_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sel_low();
    cfg_sel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_high();
    wait_clk(HALF);
    cfg_sel_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic access(input logic [7:0] h, input logic [7:0] d, output logic [7:0] rx);
    logic [7:0] dummy;
    shift_byte(h, dummy);
    shift_byte(d, rx);
  endtask

  task automatic check_all_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, {24'd0, cfg_regs[i*8 +: 8]}, {24'd0, shadow[i]});
  endtask

  task automatic t_reset();
    chk("R10 regs zero", {24'd0, cfg_regs[7:0] | cfg_regs[255:248]}, 32'd0);
    chk("R10 miso_oe low", {31'd0, miso_oe}, 32'd0);
    chk("R6 hiz idle", {31'd0, miso_oe}, 32'd0);
  endtask

  task automatic t_write_read();
    logic [7:0] rx;
    sel_low();
    chk("R6 oe when selected", {31'd0, miso_oe}, 32'd1);
    access(hdr_byte(1'b0, 5'd5), 8'hA5, rx);
    sel_high();
    chk("R4 old value on write", {24'd0, rx}, 32'h00);
    shadow[5] = 8'hA5;
    chk("R3 write lands", {24'd0, cfg_regs[5*8 +: 8]}, 32'hA5);
    sel_low();
    access(hdr_byte(1'b1, 5'd5), 8'h00, rx);
    sel_high();
    chk("R4 read value", {24'd0, rx}, 32'hA5);
    chk("R5 read no change", {24'd0, cfg_regs[5*8 +: 8]}, 32'hA5);
    sel_low();
    access(hdr_byte(1'b0, 5'd5), 8'h3C, rx);
    sel_high();
    shadow[5] = 8'h3C;
    chk("R4 old value returned", {24'd0, rx}, 32'hA5);
    check_all_regs("R2 index decode");
  endtask

  task automatic t_back_to_back();
    logic [7:0] rx;
    sel_low();
    access(hdr_byte(1'b0, 5'd0), 8'h81, rx);
    access(hdr_byte(1'b0, 5'd31), 8'h7E, rx);
    access(hdr_byte(1'b1, 5'd0), 8'h00, rx);
    wait_clk(HALF);
    chk("R8 chained read", {24'd0, rx}, 32'h81);
    sel_high();
    shadow[0] = 8'h81; shadow[31] = 8'h7E;
    check_all_regs("R8 chained writes");
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    sel_low();
    shift_byte(hdr_byte(1'b0, 5'd9), rx);
    sel_high();
    check_all_regs("R7 abort no write");
    sel_low();
    access(hdr_byte(1'b0, 5'd10), 8'h55, rx);
    sel_high();
    shadow[10] = 8'h55;
    check_all_regs("R7 next byte is header");
  endtask

  task automatic t_bad_frame();
    logic [7:0] rx;
    sel_low();
    access({1'b1, 1'b0, 5'd12, 1'b1}, 8'hEE, rx);
    access({1'b0, 1'b0, 5'd13, 1'b0}, 8'hDD, rx);
    sel_high();
    check_all_regs("R9 bad framing ignored");
  endtask

  task automatic t_priority();
    logic [7:0] rx;
    dat_sel_n = 1'b0;
    wait_clk(HALF);
    chk("R1 grant when idle", {31'd0, dat_grant}, 32'd1);
    sel_low();
    chk("R1 grant withdrawn", {31'd0, dat_grant}, 32'd0);
    access(hdr_byte(1'b0, 5'd20), 8'hC3, rx);
    sel_high();
    shadow[20] = 8'hC3;
    chk("R1 config wins", {24'd0, cfg_regs[20*8 +: 8]}, 32'hC3);
    dat_sel_n = 1'b1;
    wait_clk(HALF);
    chk("R1 grant needs data select", {31'd0, dat_grant}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) shadow[i] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_write_read();
    t_back_to_back();
    t_abort();
    t_bad_frame();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule